// File: doc/BRIEF.md
# Single-Wire LED Stream Decoder

This block listens to the self-clocked, one-wire data line that drives chains of addressable colour LEDs and recovers the pixel colours on it. The line is sampled with the system clock after a synchroniser. Each bit is timed from its own rising edge to the next one, and the length of its high phase within that period decides its value. Bits are packed most significant first into pixels of three or four 8-bit components. A long low stretch on the line marks the end of a frame.

The component order on the wire is picked with a 3-bit code. Whatever that order is, the block presents every completed pixel as fixed red, green, blue and white bytes, together with a one-cycle valid strobe. Bit and frame-gap events are also brought out as strobes. All timing limits are computed from the clock frequency parameter, so the same code works at any clock that is a whole number of megahertz.

Top module: `led_stream_decoder`

## Requirements
- R1: After reset the outputs `pixel_valid`, `bit_valid`, `reset_seen` and all colour bytes are 0. No bit is accepted until the synchronised line has been seen low once. The first frame gap after that is handled (partial bits dropped, bit reference cleared) but does not pulse `reset_seen`.
- R2: A bit is resolved at the rising edge that starts the next bit. Its value is 1 when twice its high time, in clock cycles, is greater than the rise-to-rise period, and 0 otherwise. A one-cycle `bit_valid` with `bit_value` reports it.
- R3: A low level lasting more than RESET_NS (more than RESET_NS*CLK_HZ/1e9 cycles) is a frame gap. Every gap after the first one gives exactly one `reset_seen` pulse. A gap discards any bits collected for an unfinished pixel.
- R4: A bit that is directly followed by a frame gap is resolved when the gap is detected. It is 1 when twice its high time is greater than the period of the previous bit decoded since the last gap. When no such bit exists, it is 1 when its high time is at least FALLBACK_NS.
- R5: Bits fill a pixel most significant bit first, 24 bits for 3-component orders and 32 bits for 4-component orders. `pixel_valid` pulses for exactly one cycle, the cycle after the `bit_valid` of the pixel's last bit. No pixel is produced by a partial pixel.
- R6: `wire_order` selects the wire sequence of components, first component first: 0 B,G,R; 1 B,R,G; 2 G,B,R; 3 G,R,B; 4 R,B,G; 5 R,G,B; 6 R,W,B,G; 7 R,G,B,W. The decoded bytes always appear on `r`, `g`, `b` and `w`.
- R7: For codes 0 to 5, `has_w` is 0 and `w` is 0 with each pixel. For codes 6 and 7, `has_w` is 1.
- R8: Decoding stays correct when each bit time is stretched or shortened by up to 150 ns on both phases, starting from nominal phases of 350/800 ns for 0 and 700/600 ns for 1. The last two bits before a gap are excluded from this, because of the rule in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Asynchronous LED data line |
| wire_order | input | 3 | Wire component order code (R6) |
| r | output | 8 | Red byte of last pixel |
| g | output | 8 | Green byte of last pixel |
| b | output | 8 | Blue byte of last pixel |
| w | output | 8 | White byte of last pixel, 0 without white |
| has_w | output | 1 | Last pixel had four components |
| pixel_valid | output | 1 | One-cycle strobe per completed pixel |
| bit_valid | output | 1 | One-cycle strobe per decoded bit |
| bit_value | output | 1 | Value of the bit flagged by bit_valid |
| reset_seen | output | 1 | One-cycle strobe per reported frame gap |

## Verification
The properties assume that two decoded bits are never closer than two clock cycles apart. They also assume that a frame gap is reached only after the raw line has been low for several cycles, which holds for any line whose phases last longer than a few clock periods. The stimulus uses phases of hundreds of nanoseconds at a 20 ns clock. It also changes `wire_order` only during frame gaps, because the order is applied live as each pixel completes. Jittered bit times use a deterministic pattern that stretches both phases of a bit in the same direction, and the final two bits of each jittered frame stay nominal, so that the previous-period rule for the last bit still holds.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

   typedef enum logic [2:0] {
      ORD_BGR  = 3'd0,
      ORD_BRG  = 3'd1,
      ORD_GBR  = 3'd2,
      ORD_GRB  = 3'd3,
      ORD_RBG  = 3'd4,
      ORD_RGB  = 3'd5,
      ORD_RWBG = 3'd6,
      ORD_RGBW = 3'd7
   } order_e;

   // wire slot (0 = first on the wire) holding each output component
   typedef struct packed {
      logic [1:0] pos_r;
      logic [1:0] pos_g;
      logic [1:0] pos_b;
      logic [1:0] pos_w;
      logic       has_w;
   } layout_t;

   function automatic layout_t order_layout(input logic [2:0] code);
      layout_t l;
      case (order_e'(code))
         ORD_BGR:  l = '{pos_r: 2'd2, pos_g: 2'd1, pos_b: 2'd0, pos_w: 2'd3, has_w: 1'b0};
         ORD_BRG:  l = '{pos_r: 2'd1, pos_g: 2'd2, pos_b: 2'd0, pos_w: 2'd3, has_w: 1'b0};
         ORD_GBR:  l = '{pos_r: 2'd2, pos_g: 2'd0, pos_b: 2'd1, pos_w: 2'd3, has_w: 1'b0};
         ORD_GRB:  l = '{pos_r: 2'd1, pos_g: 2'd0, pos_b: 2'd2, pos_w: 2'd3, has_w: 1'b0};
         ORD_RBG:  l = '{pos_r: 2'd0, pos_g: 2'd2, pos_b: 2'd1, pos_w: 2'd3, has_w: 1'b0};
         ORD_RGB:  l = '{pos_r: 2'd0, pos_g: 2'd1, pos_b: 2'd2, pos_w: 2'd3, has_w: 1'b0};
         ORD_RWBG: l = '{pos_r: 2'd0, pos_g: 2'd3, pos_b: 2'd2, pos_w: 2'd1, has_w: 1'b1};
         default:  l = '{pos_r: 2'd0, pos_g: 2'd1, pos_b: 2'd2, pos_w: 2'd3, has_w: 1'b1};
      endcase
      return l;
   endfunction

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   // flops reset to the idle-high guess so a real low is needed to sync
   logic [STAGES-1:0] chain;
   logic              lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         lvl_d <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         lvl_d <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/lsd_bit_timer.sv
module lsd_bit_timer #(
   parameter int RST_CYC  = 2500,
   parameter int FALL_CYC = 31
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise,
   input  logic fall,
   output logic bit_valid,
   output logic bit_value,
   output logic gap_evt,
   output logic gap_report
);
   localparam int CW = $clog2(RST_CYC + 2);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   logic          synced, in_bit, have_fall, have_prev, first_done;
   logic [CW-1:0] per_cnt, hi_cnt, low_cnt, prev_per;
   logic          dec_next, dec_last, gap_hit;

   assign dec_next = {hi_cnt, 1'b0} > {1'b0, per_cnt};
   assign dec_last = have_prev ? ({hi_cnt, 1'b0} > {1'b0, prev_per})
                               : (hi_cnt >= CW'(FALL_CYC));
   assign gap_hit  = !lvl && (low_cnt == CW'(RST_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced     <= 1'b0;
         in_bit     <= 1'b0;
         have_fall  <= 1'b0;
         have_prev  <= 1'b0;
         first_done <= 1'b0;
         per_cnt    <= '0;
         hi_cnt     <= '0;
         low_cnt    <= '0;
         prev_per   <= '0;
         bit_valid  <= 1'b0;
         bit_value  <= 1'b0;
         gap_evt    <= 1'b0;
         gap_report <= 1'b0;
      end else begin
         bit_valid  <= 1'b0;
         gap_evt    <= 1'b0;
         gap_report <= 1'b0;
         if (!synced) begin
            synced <= !lvl;
         end else begin
            per_cnt <= (per_cnt == CNT_MAX) ? per_cnt : per_cnt + 1'b1;
            if (lvl)
               low_cnt <= '0;
            else
               low_cnt <= (low_cnt == CNT_MAX) ? low_cnt : low_cnt + 1'b1;

            if (rise) begin
               if (in_bit && have_fall) begin
                  bit_valid <= 1'b1;
                  bit_value <= dec_next;
                  prev_per  <= per_cnt;
                  have_prev <= 1'b1;
               end
               in_bit    <= 1'b1;
               have_fall <= 1'b0;
               per_cnt   <= CW'(1);
            end

            if (fall && in_bit) begin
               hi_cnt    <= per_cnt;
               have_fall <= 1'b1;
            end

            if (gap_hit) begin
               if (in_bit && have_fall) begin
                  bit_valid <= 1'b1;
                  bit_value <= dec_last;
               end
               in_bit     <= 1'b0;
               have_fall  <= 1'b0;
               have_prev  <= 1'b0;
               gap_evt    <= 1'b1;
               gap_report <= first_done;
               first_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lsd_pixel_asm.sv
module lsd_pixel_asm
   import lsd_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_valid,
   input  logic                  bit_value,
   input  logic                  clr,
   input  logic [2:0]            order,
   output logic [3:0][COMP_W-1:0] comps,
   output logic                  has_w,
   output logic                  pixel_valid
);
   localparam int N_COMP = 4;
   localparam int PIX_W  = COMP_W * N_COMP;
   localparam int CNT_W  = $clog2(PIX_W + 1);

   layout_t           lay;
   logic [PIX_W-2:0]  sh;
   logic [PIX_W-1:0]  nsh, full;
   logic [CNT_W-1:0]  cnt, need;
   logic [1:0]        pos  [N_COMP];
   logic [COMP_W-1:0] wb   [N_COMP];
   logic [COMP_W-1:0] pick [N_COMP];

   assign lay  = order_layout(order);
   assign nsh  = {sh, bit_value};
   assign full = lay.has_w ? nsh : {nsh[PIX_W-COMP_W-1:0], {COMP_W{1'b0}}};
   assign need = lay.has_w ? CNT_W'(PIX_W) : CNT_W'(PIX_W - COMP_W);

   assign pos[0] = lay.pos_r;
   assign pos[1] = lay.pos_g;
   assign pos[2] = lay.pos_b;
   assign pos[3] = lay.pos_w;

   for (genvar k = 0; k < N_COMP; k++) begin : g_slot
      assign wb[k]   = full[PIX_W-1-COMP_W*k -: COMP_W];
      assign pick[k] = wb[pos[k]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh          <= '0;
         cnt         <= '0;
         comps       <= '0;
         has_w       <= 1'b0;
         pixel_valid <= 1'b0;
      end else begin
         pixel_valid <= 1'b0;
         if (bit_valid) begin
            sh <= nsh[PIX_W-2:0];
            if (cnt + 1'b1 == need) begin
               pixel_valid <= 1'b1;
               has_w       <= lay.has_w;
               for (int k = 0; k < N_COMP; k++) comps[k] <= pick[k];
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (clr) cnt <= '0;
      end
   end
endmodule

// File: rtl/led_stream_decoder.sv
module led_stream_decoder #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int RESET_NS    = 50_000,
   parameter int FALLBACK_NS = 625,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic [2:0] wire_order,
   output logic [7:0] r,
   output logic [7:0] g,
   output logic [7:0] b,
   output logic [7:0] w,
   output logic       has_w,
   output logic       pixel_valid,
   output logic       bit_valid,
   output logic       bit_value,
   output logic       reset_seen
);
   localparam int MHZ      = CLK_HZ / 1_000_000;
   localparam int RST_CYC  = MHZ * RESET_NS / 1000;
   localparam int FALL_CYC = MHZ * FALLBACK_NS / 1000;

   if (CLK_HZ % 1_000_000 != 0) begin : g_bad_clk
      $error("CLK_HZ must be a whole number of MHz");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FALL_CYC < 4 || RST_CYC <= 4 * FALL_CYC) begin : g_bad_time
      $error("timing parameters out of range for this clock");
   end

   logic lvl, rise, fall, gap_evt;
   logic [3:0][7:0] comps;

   lsd_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk), .rst_n (rst_n), .din (din),
      .lvl (lvl), .rise (rise), .fall (fall)
   );

   lsd_bit_timer #(.RST_CYC(RST_CYC), .FALL_CYC(FALL_CYC)) i_timer (
      .clk (clk), .rst_n (rst_n), .lvl (lvl), .rise (rise), .fall (fall),
      .bit_valid (bit_valid), .bit_value (bit_value),
      .gap_evt (gap_evt), .gap_report (reset_seen)
   );

   lsd_pixel_asm #(.COMP_W(8)) i_asm (
      .clk (clk), .rst_n (rst_n), .bit_valid (bit_valid), .bit_value (bit_value),
      .clr (gap_evt), .order (wire_order), .comps (comps),
      .has_w (has_w), .pixel_valid (pixel_valid)
   );

   assign r = comps[0];
   assign g = comps[1];
   assign b = comps[2];
   assign w = comps[3];
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       din,
   input logic       bit_valid,
   input logic       pixel_valid,
   input logic       reset_seen,
   input logic       has_w,
   input logic [7:0] w
);
   assert_pixel_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pixel_valid |-> $past(bit_valid));

   assert_w_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pixel_valid && !has_w) |-> (w == 8'h00));

   assert_gap_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |-> (!$past(din, 3) && !$past(din, 4)));

   assert_bits_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> !bit_valid);
endmodule

bind led_stream_decoder lsd_checker i_chk (.*);

// File: tb/test_led_stream_decoder.sv
`timescale 1ns/1ps
module test_led_stream_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din = 1'b1;
   logic [2:0] wire_order = 3'd3;
   logic [7:0] r, g, b, w;
   logic       has_w, pixel_valid, bit_valid, bit_value, reset_seen;

   int checks = 0;
   int errors = 0;
   int nbits = 0;
   int nrst = 0;
   int exp_rst = 0;
   int jseq = 0;
   bit last_bit = 1'b0;
   bit done = 1'b0;
   logic [32:0] expq[$];

   always #10 clk = ~clk;

   led_stream_decoder i_led_stream_decoder (
      .clk (clk), .rst_n (rst_n), .din (din), .wire_order (wire_order),
      .r (r), .g (g), .b (b), .w (w), .has_w (has_w),
      .pixel_valid (pixel_valid), .bit_valid (bit_valid),
      .bit_value (bit_value), .reset_seen (reset_seen)
   );

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (bit_valid) begin
            last_bit = bit_value;
            nbits++;
         end
         if (reset_seen) nrst++;
         if (pixel_valid) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R5 unexpected pixel", {31'd0, has_w, r, g, b, w}, 64'd0);
            end else begin
               logic [32:0] e;
               e = expq.pop_front();
               chk({has_w, r, g, b, w} == e, "R6 pixel bytes (R2 R5 R7 R8)",
                   {31'd0, has_w, r, g, b, w}, {31'd0, e});
            end
         end
      end
   end

   task automatic drive(input int hi, input int lo);
      din = 1'b1; #(hi);
      din = 1'b0; #(lo);
   endtask

   task automatic send_bit(input bit v, input int j);
      if (v) drive(700 + j, 600 + j);
      else   drive(350 + j, 800 + j);
   endtask

   task automatic gap();
      din = 1'b0;
      #55000;
   endtask

   task automatic gap_reported();
      gap();
      exp_rst++;
      chk(nrst == exp_rst, "R3 gap reported once", nrst, exp_rst);
   endtask

   task automatic send_pixel(input logic [7:0] pr, pg, pb, pw,
                             input logic [2:0] ord, input bit jit_en, input bit last);
      logic [31:0] word;
      bit hw;
      int n;
      hw = (ord >= 3'd6);
      n  = hw ? 32 : 24;
      case (ord)
         3'd0: word = {pb, pg, pr, 8'h00};
         3'd1: word = {pb, pr, pg, 8'h00};
         3'd2: word = {pg, pb, pr, 8'h00};
         3'd3: word = {pg, pr, pb, 8'h00};
         3'd4: word = {pr, pb, pg, 8'h00};
         3'd5: word = {pr, pg, pb, 8'h00};
         3'd6: word = {pr, pw, pb, pg};
         default: word = {pr, pg, pb, pw};
      endcase
      expq.push_back({hw, pr, pg, pb, hw ? pw : 8'h00});
      for (int i = 0; i < n; i++) begin
         int j;
         j = 0;
         if (jit_en && !(last && i >= n - 2)) begin
            j = ((jseq % 3) - 1) * 150;
            jseq++;
         end
         send_bit(word[31-i], j);
      end
   endtask

   initial begin : watchdog
      #3_600_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int nb;
      #5;
      #100 rst_n = 1'b1;
      #20;
      // R1 reset state
      chk({pixel_valid, bit_valid, reset_seen, r, g, b, w, has_w} == 0, "R1 reset state",
          {pixel_valid, bit_valid, reset_seen, r, g, b, w, has_w}, 0);
      // R1: line high, then first low gap is not reported
      #2000;
      gap();
      chk(nrst == 0, "R1 first gap silent", nrst, 0);
      chk(nbits == 0, "R1 no bits before data", nbits, 0);

      // R6: every wire order, two pixels per frame
      for (int o = 0; o < 8; o++) begin
         wire_order = 3'(o);
         send_pixel(8'hA5 ^ 8'(o), 8'h3C + 8'(o), 8'h81, 8'h5E ^ 8'(o * 3), 3'(o), 1'b0, 1'b0);
         send_pixel(8'h0F, 8'hF0 - 8'(o), 8'h69 ^ 8'(o), 8'hC3, 3'(o), 1'b0, 1'b1);
         gap_reported();
         chk(expq.size() == 0, "R6 all pixels seen", expq.size(), 0);
      end

      // R8: jittered bit times
      wire_order = 3'd3;
      send_pixel(8'h12, 8'hED, 8'h55, 8'h00, 3'd3, 1'b1, 1'b0);
      send_pixel(8'hFF, 8'h00, 8'hAA, 8'h00, 3'd3, 1'b1, 1'b0);
      send_pixel(8'h96, 8'h6B, 8'h01, 8'h00, 3'd3, 1'b1, 1'b1);
      gap_reported();
      chk(expq.size() == 0, "R8 jitter GRB pixels", expq.size(), 0);
      wire_order = 3'd7;
      send_pixel(8'hC8, 8'h37, 8'h9D, 8'h62, 3'd7, 1'b1, 1'b0);
      send_pixel(8'h01, 8'h80, 8'h7F, 8'hFE, 3'd7, 1'b1, 1'b1);
      gap_reported();
      chk(expq.size() == 0, "R8 jitter RGBW pixels", expq.size(), 0);

      // R3: partial pixel is dropped at a gap
      wire_order = 3'd3;
      for (int i = 0; i < 10; i++) send_bit(1'b1, 0);
      gap_reported();
      send_pixel(8'h24, 8'h42, 8'h99, 8'h00, 3'd3, 1'b0, 1'b1);
      gap_reported();
      chk(expq.size() == 0, "R3 pixel after partial clear", expq.size(), 0);

      // R4: last bit judged against previous period (2000 ns)
      nb = nbits;
      for (int i = 0; i < 4; i++) drive(400, 1600);
      din = 1'b1; #800;
      gap_reported();
      chk(nbits == nb + 5, "R4 bit count with gap", nbits, nb + 5);
      chk(last_bit == 1'b0, "R4 last bit vs previous period", last_bit, 0);

      // R4: lone bits use the fixed threshold
      din = 1'b1; #800;
      gap_reported();
      chk(last_bit == 1'b1, "R4 lone long high", last_bit, 1);
      din = 1'b1; #400;
      gap_reported();
      chk(last_bit == 1'b0, "R4 lone short high", last_bit, 0);
      chk(expq.size() == 0, "R5 queue empty at end", expq.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule